// File: doc/BRIEF.md
# Three-Mode Latch/Register Bus Driver

This block moves a parallel data word from an input bus to an output bus in one of three ways, chosen by a latch-enable level and a capture clock. With latch enable high, the word passes straight through. With latch enable low, a rising capture-clock edge loads the present input. Between edges, and after latch enable drops, the last value is held. Every bit is built from two level-sensitive stages in series. A control decoder opens the first stage while the capture clock is low and the second stage while it is high, and latch enable opens both stages.

An active-low output enable sets a per-bit drive qualifier. When the drive is off, the data output reads zero. A top level can turn the qualifier and data into a three-state pad. Output enable acts only on the drive path. Anything loaded while the outputs are off shows up as soon as they are enabled again. An active-high clear empties both stages.

Top module: `mode_bus_driver`

## Requirements
- R1: While `oe_n` is 1, `drv_en` is all zeros and `dout` is all zeros. This holds whatever `le`, `cap_clk` and `din` do.
- R2: While `oe_n` is 0, `drv_en` is all ones and `dout` shows the stored or passed word.
- R3: While `le` is 1, `dout` follows `din` with no clock, and edges on `cap_clk` change nothing.
- R4: While `le` is 0, a rising edge of `cap_clk` loads the `din` value present at that edge.
- R5: While `le` is 0 and `cap_clk` stays 1, the output holds. If `le` fell while `cap_clk` was 1, the value held is the `din` present as `le` fell.
- R6: While `le` is 0 and `cap_clk` stays 0, the output holds. If `le` fell while `cap_clk` was 0, the output keeps the `din` present as `le` fell, and the next rising edge loads the then-current `din`.
- R7: `oe_n` does not alter stored data. A word loaded while `oe_n` is 1 appears on `dout` once `oe_n` returns to 0.
- R8: While `rst` is 1, the stored word is cleared to zero, even with `le` at 1. The zero remains after `rst` falls, until new data is loaded.
- R9: With `le` at 0, a falling edge of `cap_clk` leaves `dout` unchanged.
- R10: Each of the `WIDTH` bits (default 18) is stored independently. A single set bit at any position is reproduced at the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high clear of both storage stages |
| cap_clk | input | 1 | Capture clock; the rising edge loads when `le` is 0 |
| le | input | 1 | Latch enable; 1 makes the path transparent |
| oe_n | input | 1 | Active-low output enable |
| din | input | WIDTH | Input data word |
| dout | output | WIDTH | Output data word, zero while the drive is off |
| drv_en | output | WIDTH | Per-bit drive qualifier for a three-state pad |

## Verification
The bench targets the two ways `le` can fall: with the capture clock high and with it low. A design that swapped the stage enables would capture on the falling edge. It would also hold a stale word after `le` drops with the clock high. The bench toggles `cap_clk` during transparent mode, so a design that let the clock through would show an early load. It also loads data while the outputs are off. A design that gated storage with `oe_n` would then present an old word when the drive returns, and a design that reset only one stage would leak data through after a clear.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    localparam int DEF_WIDTH = 18;

    typedef struct packed {
        logic clear;
        logic first_open;
        logic second_open;
    } stage_ctrl_t;

    // First stage follows while the capture clock is low, second while high;
    // latch enable opens both.
    function automatic stage_ctrl_t decode_stages(input logic clr,
                                                  input logic ck,
                                                  input logic pass);
        stage_ctrl_t c;
        c.clear       = clr;
        c.first_open  = pass | ~ck;
        c.second_open = pass | ck;
        return c;
    endfunction

endpackage

// File: rtl/mbd_ctrl.sv
module mbd_ctrl
    import mbd_pkg::*;
(
    input  logic        rst,
    input  logic        cap_clk,
    input  logic        le,
    output stage_ctrl_t ctrl
);

    always_comb begin
        ctrl = decode_stages(rst, cap_clk, le);
    end

endmodule

// File: rtl/mbd_cell.sv
module mbd_cell
    import mbd_pkg::*;
(
    input  logic        ck,
    input  stage_ctrl_t ctrl,
    input  logic        d,
    output logic        q
);

    logic first_q;
    logic second_q;

    always_latch begin
        if (ctrl.clear)
            first_q <= 1'b0;
        else if (ctrl.first_open)
            first_q <= d;
    end

    always_latch begin
        if (ctrl.clear)
            second_q <= 1'b0;
        else if (ctrl.second_open)
            second_q <= first_q;
    end

    assign q = second_q;

    // R3: with both stages open, they must carry the same bit
    a_r3_stages_agree: assert property (@(posedge ck) disable iff (ctrl.clear)
        (ctrl.first_open && ctrl.second_open) |-> (first_q == second_q));

endmodule

// File: rtl/mbd_drive.sv
module mbd_drive #(
    parameter int WIDTH = 18
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] drv_en
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_gate
        assign drv_en[b] = ~oe_n;
        assign dout[b]   = held[b] & ~oe_n;
    end

endmodule

// File: rtl/mode_bus_driver.sv
module mode_bus_driver
    import mbd_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             rst,
    input  logic             cap_clk,
    input  logic             le,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] drv_en
);

    localparam logic [WIDTH-1:0] ALL_ON = {WIDTH{1'b1}};

    stage_ctrl_t      ctrl;
    logic [WIDTH-1:0] stored;

    mbd_ctrl u_ctrl (
        .rst     (rst),
        .cap_clk (cap_clk),
        .le      (le),
        .ctrl    (ctrl)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        mbd_cell u_cell (
            .ck   (cap_clk),
            .ctrl (ctrl),
            .d    (din[b]),
            .q    (stored[b])
        );
    end

    mbd_drive #(.WIDTH(WIDTH)) u_drive (
        .oe_n   (oe_n),
        .held   (stored),
        .dout   (dout),
        .drv_en (drv_en)
    );

    // R1: drive off means quiet outputs
    a_r1_quiet_when_off: assert property (@(posedge cap_clk) disable iff (rst)
        oe_n |-> (dout == '0 && drv_en == '0));

    // R2: drive on presents the stored word on every bit
    a_r2_drive_on: assert property (@(posedge cap_clk) disable iff (rst)
        !oe_n |-> (dout == stored && drv_en == ALL_ON));

    // R3: transparent mode tracks the input
    a_r3_pass_follows: assert property (@(posedge cap_clk) disable iff (rst)
        le |-> (stored == din));

endmodule

// File: tb/tb_mode_bus_driver.sv
`timescale 1ns/1ps
module tb_mode_bus_driver;

    localparam int W = 18;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1;
    logic cap_clk = 1'b0;
    logic le = 1'b0;
    logic oe_n = 1'b0;
    logic [W-1:0] din = '1;
    logic [W-1:0] dout;
    logic [W-1:0] drv_en;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string phase = "R8";

    mode_bus_driver #(.WIDTH(W)) dut (
        .rst(rst), .cap_clk(cap_clk), .le(le), .oe_n(oe_n),
        .din(din), .dout(dout), .drv_en(drv_en)
    );

    // behavioural reference: value visible when enabled
    logic [W-1:0] ref_q = '0;
    logic prev_ck = 1'b0;
    always @(cap_clk or le or din or rst) begin
        if (rst) ref_q = '0;
        else if (le) ref_q = din;
        else if (cap_clk && !prev_ck) ref_q = din;
        prev_ck = cap_clk;
    end

    // compare on every clock, away from the stimulus instants
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (dout !== (oe_n ? '0 : ref_q) || drv_en !== (oe_n ? '0 : ONES)) begin
                fails++;
                $display("FAIL %s model: dout=%h en=%h expected dout=%h en=%h",
                         phase, dout, drv_en, oe_n ? '0 : ref_q, oe_n ? '0 : ONES);
            end
        end
    end

    task automatic step();
        @(posedge clk); #3;
    endtask

    task automatic expect_out(input string req, input logic [W-1:0] exp_d,
                              input logic [W-1:0] exp_e);
        @(negedge clk); #1;
        checks++;
        if (dout !== exp_d || drv_en !== exp_e) begin
            fails++;
            $display("FAIL %s: dout=%h en=%h expected dout=%h en=%h",
                     req, dout, drv_en, exp_d, exp_e);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: clear while asserted
        step(); expect_out("R8", '0, ONES);
        step(); rst = 1'b0;
        expect_out("R8", '0, ONES);

        // R4, R5, R9: clocked mode
        phase = "R4";
        step(); din = 18'h2A5A5;
        step(); cap_clk = 1'b1;
        expect_out("R4", 18'h2A5A5, ONES);
        phase = "R5";
        step(); din = 18'h15A5A;
        expect_out("R5", 18'h2A5A5, ONES);
        phase = "R9";
        step(); cap_clk = 1'b0;
        expect_out("R9", 18'h2A5A5, ONES);

        // R3: transparent mode, clock ignored
        phase = "R3";
        step(); le = 1'b1;
        expect_out("R3", 18'h15A5A, ONES);
        step(); din = 18'h0F0F0;
        expect_out("R3", 18'h0F0F0, ONES);
        step(); cap_clk = 1'b1;
        step(); din = 18'h30303;
        expect_out("R3", 18'h30303, ONES);

        // R5: latch enable falls with the clock high
        phase = "R5";
        step(); din = 18'h11111;
        step(); le = 1'b0;
        expect_out("R5", 18'h11111, ONES);
        step(); din = 18'h22222;
        expect_out("R5", 18'h11111, ONES);

        // R6: latch enable falls with the clock low
        phase = "R6";
        step(); cap_clk = 1'b0;
        expect_out("R6", 18'h11111, ONES);
        step(); le = 1'b1;
        step(); din = 18'h33333;
        step(); le = 1'b0;
        step(); din = 18'h04444;
        expect_out("R6", 18'h33333, ONES);
        step(); cap_clk = 1'b1;
        expect_out("R6", 18'h04444, ONES);

        // R1, R7: capture while the drive is off
        phase = "R1";
        step(); oe_n = 1'b1;
        expect_out("R1", '0, '0);
        step(); cap_clk = 1'b0;
        step(); din = 18'h3C3C3;
        step(); cap_clk = 1'b1;
        expect_out("R1", '0, '0);
        step(); le = 1'b1;
        step(); din = 18'h00F0F;
        expect_out("R1", '0, '0);
        step(); le = 1'b0;
        step(); din = 18'h12345;
        phase = "R7";
        step(); oe_n = 1'b0;
        expect_out("R7", 18'h00F0F, ONES);
        phase = "R2";
        expect_out("R2", 18'h00F0F, ONES);

        // R8: clear overrides transparent mode
        phase = "R8";
        step(); le = 1'b1;
        step(); rst = 1'b1;
        expect_out("R8", '0, ONES);
        step(); le = 1'b0;
        step(); rst = 1'b0;
        step(); din = 18'h3FFFF;
        expect_out("R8", '0, ONES);

        // R10: walking one through every bit position
        phase = "R10";
        step(); cap_clk = 1'b0;
        for (int i = 0; i < W; i++) begin
            step(); din = W'(1) << i;
            step(); cap_clk = 1'b1;
            expect_out("R10", W'(1) << i, ONES);
            step(); cap_clk = 1'b0;
        end

        step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule